// File: doc/BRIEF.md
# Parallel Converter Host Controller

This block sits on the host side of a 14-bit sampling converter whose results come out on a parallel bus that both sides can drive. While `run` is high it issues active-low conversion-start pulses at a fixed minimum spacing. It follows the converter's busy flag through each conversion. When busy returns high it reads the result with the chip-select and read strobes and hands the word downstream as a one-cycle `res_valid` with data. A host can also request that a 14-bit offset word be written into the converter. The controller drives that word onto the shared bus under chip-select and pulses the write strobe. The converter takes the word on the falling edge of that strobe.

The converter has two latching behaviours, and `latch_mode2` picks one at each conversion start. In the direct behaviour, busy rises only after the new result is in the converter's output register, so the word read belongs to the conversion just finished. In the deferred behaviour, the output register is loaded on the next start pulse. Each word read then belongs to the conversion before, and the controller tags it with `res_prev`. Two level outputs, standby and nap, pass host requests to the converter's power pins and hold off new conversions. A watchdog on the busy flag reports a conversion that never completes.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset the strobes are idle (`adc_convst_n`, `adc_cs_n`, `adc_rd_n` high; `adc_wr`, `bus_oe`, `res_valid`, `err_timeout`, `ofs_ack` low).
- R2: Each start pulse holds `adc_convst_n` low for exactly CONV_W cycles. Falling edges of `adc_convst_n` are at least max(START_CYC, ceil(CLK_MHZ/3)) cycles apart, so the pulses never come faster than 3 million per second.
- R3: `adc_stby` and `adc_nap` follow `stby_req` and `nap_req` one cycle later. No start pulse begins while either request or either output is high.
- R4: With `latch_mode2`=0 at start, the word on `bus_in` is captured after busy returns high and appears on `res_data` with `res_prev`=0. Bit 13 of the bus is the MSB of the result.
- R5: With `latch_mode2`=1 at start, results carry `res_prev`=1 and hold the result of the preceding conversion. The first such conversion after reset, after a direct-mode conversion, after a timeout or after standby/nap emits no result.
- R6: `bus_oe` is never high in a cycle where `adc_rd_n` is low, and `bus_oe` is low in the cycle before `adc_rd_n` falls.
- R7: A read holds `adc_cs_n` and `adc_rd_n` low together for RD_W cycles and samples the bus in the last of them. Results stay correct when the converter ignores chip-select (chip-select tied low at the converter).
- R8: An offset write drives `bus_oe` with the word under `adc_cs_n` low, raises `adc_wr` for WR_W cycles and keeps the word driven for one cycle after `adc_wr` falls. The converter then holds the requested word, and `ofs_ack` pulses once.
- R9: If busy does not go low and then high again within TO_CYC cycles of the end of the start pulse, `err_timeout` pulses for one cycle exactly TO_CYC cycles after `adc_convst_n` rises. No result is emitted for that conversion.
- R10: An offset write requested during a conversion waits until that conversion's read has finished. A pending write goes ahead of a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Keep converting while high |
| latch_mode2 | input | 1 | 1 selects deferred latching, sampled at each start |
| stby_req | input | 1 | Standby request |
| nap_req | input | 1 | Nap request |
| ofs_wr_req | input | 1 | One-cycle request to write the offset word |
| ofs_word | input | 14 | Offset word captured with the request |
| ofs_ack | output | 1 | Pulses when the offset write completes |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 14 | Result word |
| res_prev | output | 1 | Result belongs to the preceding conversion |
| err_timeout | output | 1 | One-cycle busy-timeout pulse |
| adc_convst_n | output | 1 | Conversion start, active low |
| adc_busy | input | 1 | Converter busy flag, low while converting |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_wr | output | 1 | Write strobe, active high |
| adc_stby | output | 1 | Standby level to the converter |
| adc_nap | output | 1 | Nap level to the converter |
| bus_in | input | 14 | Data bus as seen at the host |
| bus_out | output | 14 | Host drive value for the data bus |
| bus_oe | output | 1 | Host bus driver enable |

## Verification
The hardest situations to reach are the ones where deferred latching must throw away a result: the first deferred conversion after a direct one, after a timeout or after a power-down request. The bench's converter model has a knob that keeps busy low for good, which forces the timeout. Standby is raised between deferred runs, so the dropped first result shows up as one extra start pulse in the count compared with the results delivered. A write request placed while busy is low checks that the write is held back.

// File: rtl/adc_host_pkg.sv
// Shared types for the parallel converter host controller.
// Assumes: nothing beyond the standard language.
package adc_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CONV,
        ST_BLO,
        ST_BHI,
        ST_GAP,
        ST_READ,
        ST_WSET,
        ST_WPUL,
        ST_WHOLD
    } host_st_t;

    // Larger of two integers, used to size shared counters.
    function automatic int pmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_bit_sync.sv
// Brings one asynchronous level into the clock domain through a chain of flops.
// Assumes: STAGES >= 1; the reset value matches the idle level of the input.
module adc_bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            // Shift the input through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_step_timer.sv
// Loadable down-counter used for strobe widths, gaps and the busy timeout.
// Assumes: a load of N yields zero after N further cycles; holds at zero.
module adc_step_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/adc_start_pacer.sv
// Enforces the minimum spacing between conversion starts.
// Assumes: start is raised only while ready is high; ready right after reset.
module adc_start_pacer #(
    parameter int PERIOD = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    localparam int PW = $clog2(PERIOD + 1);
    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

    logic [PW-1:0] cnt;

    // Restart on a start, otherwise count up and hold at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= LAST;
        else if (start)      cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign ready = (cnt == LAST);
endmodule

// File: rtl/adc_host_ctrl.sv
// Host-side controller for a parallel-output sampling converter: paced start
// pulses, busy tracking with timeout, strobed reads, offset-word writes and
// the two result-latching behaviours.
// Assumes: adc_busy may be asynchronous (it is synchronised); bus_in carries
// the converter's drive whenever adc_rd_n is low; all strobe widths >= 1.
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int DW          = 14,
    parameter int CLK_MHZ     = 250,
    parameter int START_CYC   = 84,
    parameter int CONV_W      = 3,
    parameter int GAP_W       = 2,
    parameter int RD_W        = 3,
    parameter int WR_W        = 3,
    parameter int TO_CYC      = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          latch_mode2,
    input  logic          stby_req,
    input  logic          nap_req,
    input  logic          ofs_wr_req,
    input  logic [DW-1:0] ofs_word,
    output logic          ofs_ack,
    output logic          res_valid,
    output logic [DW-1:0] res_data,
    output logic          res_prev,
    output logic          err_timeout,
    output logic          adc_convst_n,
    input  logic          adc_busy,
    output logic          adc_cs_n,
    output logic          adc_rd_n,
    output logic          adc_wr,
    output logic          adc_stby,
    output logic          adc_nap,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe
);
    localparam int MIN_START = (CLK_MHZ + 2) / 3;
    localparam int EFF_START = pmax(START_CYC, MIN_START);
    localparam int TMAX      = pmax(pmax(pmax(CONV_W, GAP_W), pmax(RD_W, WR_W)), TO_CYC);
    localparam int TW        = $clog2(TMAX + 1);

    host_st_t      st, st_nx;
    logic          t_load, t_zero;
    logic [TW-1:0] t_val;
    logic          period_ok, busy_s;
    logic          start, to_hit, rd_done, wr_done;
    logic [DW-1:0] ofs_q;
    logic          ofs_pend, mode_q, have_prev;

    adc_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_busy_sync (
        .clk(clk), .rst_n(rst_n), .d(adc_busy), .q(busy_s)
    );

    adc_step_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .zero(t_zero)
    );

    adc_start_pacer #(.PERIOD(EFF_START)) u_pacer (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(period_ok)
    );

    // Next-state logic, timer loads and one-cycle events.
    always_comb begin
        st_nx   = st;
        t_load  = 1'b0;
        t_val   = '0;
        start   = 1'b0;
        to_hit  = 1'b0;
        rd_done = 1'b0;
        wr_done = 1'b0;
        case (st)
            ST_IDLE: begin
                if (ofs_pend) begin
                    st_nx  = ST_WSET;
                    t_load = 1'b1;
                    t_val  = TW'(GAP_W - 1);
                end else if (run && period_ok && !stby_req && !nap_req
                             && !adc_stby && !adc_nap) begin
                    st_nx  = ST_CONV;
                    t_load = 1'b1;
                    t_val  = TW'(CONV_W - 1);
                    start  = 1'b1;
                end
            end
            ST_CONV: if (t_zero) begin
                st_nx  = ST_BLO;
                t_load = 1'b1;
                t_val  = TW'(TO_CYC - 1);
            end
            ST_BLO: begin
                if (!busy_s) st_nx = ST_BHI;
                else if (t_zero) begin
                    st_nx  = ST_IDLE;
                    to_hit = 1'b1;
                end
            end
            ST_BHI: begin
                if (busy_s) begin
                    st_nx  = ST_GAP;
                    t_load = 1'b1;
                    t_val  = TW'(GAP_W - 1);
                end else if (t_zero) begin
                    st_nx  = ST_IDLE;
                    to_hit = 1'b1;
                end
            end
            ST_GAP: if (t_zero) begin
                st_nx  = ST_READ;
                t_load = 1'b1;
                t_val  = TW'(RD_W - 1);
            end
            ST_READ: if (t_zero) begin
                st_nx   = ST_IDLE;
                rd_done = 1'b1;
            end
            ST_WSET: if (t_zero) begin
                st_nx  = ST_WPUL;
                t_load = 1'b1;
                t_val  = TW'(WR_W - 1);
            end
            ST_WPUL: if (t_zero) st_nx = ST_WHOLD;
            ST_WHOLD: begin
                st_nx   = ST_IDLE;
                wr_done = 1'b1;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Offset request capture; held until the write finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_pend <= 1'b0;
            ofs_q    <= '0;
            ofs_ack  <= 1'b0;
        end else begin
            ofs_ack <= wr_done;
            if (wr_done) ofs_pend <= 1'b0;
            else if (ofs_wr_req && !ofs_pend) begin
                ofs_pend <= 1'b1;
                ofs_q    <= ofs_word;
            end
        end
    end

    // Power-pin levels follow the requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_stby <= 1'b0;
            adc_nap  <= 1'b0;
        end else begin
            adc_stby <= stby_req;
            adc_nap  <= nap_req;
        end
    end

    // Result capture, latching-mode bookkeeping and timeout report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= 1'b0;
            have_prev   <= 1'b0;
            res_valid   <= 1'b0;
            res_data    <= '0;
            res_prev    <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            res_valid   <= 1'b0;
            err_timeout <= to_hit;
            if (start) begin
                mode_q <= latch_mode2;
                if (!latch_mode2) have_prev <= 1'b0;
            end
            if (rd_done) begin
                res_valid <= !mode_q || have_prev;
                res_data  <= bus_in;
                res_prev  <= mode_q;
                if (mode_q) have_prev <= 1'b1;
            end
            if (to_hit || adc_stby || adc_nap) have_prev <= 1'b0;
        end
    end

    // Pin decode from the state.
    always_comb begin
        adc_convst_n = (st != ST_CONV);
        adc_rd_n     = (st != ST_READ);
        adc_wr       = (st == ST_WPUL);
        bus_oe       = (st == ST_WSET) || (st == ST_WPUL) || (st == ST_WHOLD);
        adc_cs_n     = !(bus_oe || (st == ST_READ));
        bus_out      = ofs_q;
    end
endmodule

// File: rtl/adc_host_ctrl_chk.sv
// Protocol checker for adc_host_ctrl, attached by bind.
// Assumes: the same CLK_MHZ, START_CYC and CONV_W as the checked instance.
module adc_host_ctrl_chk #(
    parameter int DW        = 14,
    parameter int CLK_MHZ   = 250,
    parameter int START_CYC = 84,
    parameter int CONV_W    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adc_convst_n,
    input logic          adc_cs_n,
    input logic          adc_rd_n,
    input logic          adc_wr,
    input logic          adc_stby,
    input logic          adc_nap,
    input logic          bus_oe,
    input logic [DW-1:0] bus_out,
    input logic          res_valid,
    input logic          err_timeout
);
    localparam int MIN_START = (CLK_MHZ + 2) / 3;
    localparam int EFF_START = (START_CYC > MIN_START) ? START_CYC : MIN_START;
    localparam int GW = $clog2(EFF_START + 1);
    localparam int LW = $clog2(CONV_W + 2);

    logic          cv_q, seen;
    logic [GW-1:0] gap_cnt;
    logic [LW-1:0] low_cnt;

    // Cycles since the last start edge and width of the current pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cv_q    <= 1'b1;
            seen    <= 1'b0;
            gap_cnt <= '0;
            low_cnt <= '0;
        end else begin
            cv_q <= adc_convst_n;
            if (cv_q && !adc_convst_n) begin
                seen    <= 1'b1;
                gap_cnt <= GW'(1);
            end else if (gap_cnt != GW'(EFF_START)) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
            if (!adc_convst_n) begin
                if (low_cnt != LW'(CONV_W + 1)) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
            end
        end
    end

    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_convst_n) |-> (low_cnt == LW'(CONV_W)));
    a_r2_start_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_convst_n) && seen) |-> (gap_cnt >= GW'(EFF_START)));
    a_r3_no_start_low_power: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_convst_n) |-> (!adc_stby && !adc_nap));
    a_r6_rd_excludes_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> !bus_oe);
    a_r6_oe_released_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_rd_n) |-> $past(!bus_oe));
    a_r7_rd_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> !adc_cs_n);
    a_r7_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(!adc_rd_n));
    a_r8_wr_framed: assert property (@(posedge clk) disable iff (!rst_n)
        adc_wr |-> (!adc_cs_n && bus_oe));
    a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_wr) |-> (bus_oe && !adc_cs_n && $stable(bus_out)));
    a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> !err_timeout);
    a_r9_err_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> !res_valid);
endmodule

bind adc_host_ctrl adc_host_ctrl_chk #(
    .DW(DW), .CLK_MHZ(CLK_MHZ), .START_CYC(START_CYC), .CONV_W(CONV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n),
    .adc_rd_n(adc_rd_n), .adc_wr(adc_wr), .adc_stby(adc_stby), .adc_nap(adc_nap),
    .bus_oe(bus_oe), .bus_out(bus_out), .res_valid(res_valid),
    .err_timeout(err_timeout)
);

// File: tb/adc_host_ctrl_test.sv
module adc_host_ctrl_test;
    localparam int DW = 14, TO = 200, EFF = 84;
    localparam int CONV_W = 3, RD_W = 3, WR_W = 3, CONV_T = 20;
    // Vector fields: [7] deferred latching, [6] chip-select ignored, [5:0] results.
    localparam logic [7:0] VEC [6] = '{
        {1'b0, 1'b0, 6'd3}, {1'b0, 1'b1, 6'd2}, {1'b1, 1'b0, 6'd3},
        {1'b1, 1'b1, 6'd2}, {1'b0, 1'b0, 6'd2}, {1'b1, 1'b1, 6'd2}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, run, latch_mode2, stby_req, nap_req, ofs_wr_req;
    logic [DW-1:0] ofs_word, res_data, bus_in, bus_out;
    logic ofs_ack, res_valid, res_prev, err_timeout, adc_convst_n, adc_busy;
    logic adc_cs_n, adc_rd_n, adc_wr, adc_stby, adc_nap, bus_oe;

    adc_host_ctrl #(.TO_CYC(TO)) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .latch_mode2(latch_mode2),
        .stby_req(stby_req), .nap_req(nap_req), .ofs_wr_req(ofs_wr_req),
        .ofs_word(ofs_word), .ofs_ack(ofs_ack), .res_valid(res_valid),
        .res_data(res_data), .res_prev(res_prev), .err_timeout(err_timeout),
        .adc_convst_n(adc_convst_n), .adc_busy(adc_busy), .adc_cs_n(adc_cs_n),
        .adc_rd_n(adc_rd_n), .adc_wr(adc_wr), .adc_stby(adc_stby),
        .adc_nap(adc_nap), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    function automatic logic [DW-1:0] samp(input int i);
        return DW'((i * 613 + 91) & 16'h3fff);
    endfunction

    // Behavioural converter model.
    logic [DW-1:0] m_out, m_done, m_ofs;
    int   m_idx, m_c;
    logic conv_q, wr_q, stuck, tie_cs, m_drv;
    assign m_drv    = !adc_rd_n && (!adc_cs_n || tie_cs);
    assign bus_in   = m_drv ? m_out : (bus_oe ? bus_out : '0);
    always @(posedge clk) begin
        if (!rst_n) begin
            adc_busy <= 1'b1; conv_q <= 1'b1; wr_q <= 1'b0; m_idx <= 0; m_c <= 0;
            m_out <= '0; m_done <= '0; m_ofs <= '0;
        end else begin
            conv_q <= adc_convst_n;
            wr_q   <= adc_wr;
            if (wr_q && !adc_wr && (!adc_cs_n || tie_cs)) m_ofs <= bus_in;
            if (conv_q && !adc_convst_n) begin
                m_idx <= m_idx + 1; m_c <= CONV_T; adc_busy <= 1'b0;
                if (latch_mode2) m_out <= m_done;
            end else if (m_c > 1) begin
                m_c <= m_c - 1;
            end else if (m_c == 1) begin
                m_c <= 0;
                if (!stuck) begin
                    adc_busy <= 1'b1; m_done <= samp(m_idx);
                    if (!latch_mode2) m_out <= samp(m_idx);
                end
            end
        end
    end

    // Bench monitors: edges, widths, spacing, conflicts.
    int cyc = 0, falls = 0, last_fall = -1, min_space = 1 << 30;
    int lo_run = 0, lo_w = 0, rd_run = 0, rd_w = 0, wr_run = 0, wr_w = 0;
    int conflicts = 0, valids = 0, errs = 0;
    logic cv_p = 1'b1;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            cv_p <= adc_convst_n;
            if (cv_p && !adc_convst_n) begin
                falls <= falls + 1;
                if (last_fall >= 0 && cyc - last_fall < min_space) min_space <= cyc - last_fall;
                last_fall <= cyc;
            end
            if (!adc_convst_n) lo_run <= lo_run + 1; else begin if (lo_run > 0) lo_w <= lo_run; lo_run <= 0; end
            if (!adc_rd_n && !adc_cs_n) rd_run <= rd_run + 1; else begin if (rd_run > 0) rd_w <= rd_run; rd_run <= 0; end
            if (adc_wr) wr_run <= wr_run + 1; else begin if (wr_run > 0) wr_w <= wr_run; wr_run <= 0; end
            if (bus_oe && !adc_rd_n) conflicts <= conflicts + 1;
            if (res_valid) valids <= valids + 1;
            if (err_timeout) errs <= errs + 1;
        end
    end

    int checks = 0, bad = 0;
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    // Wait for res_valid and check it against the model's conversion index.
    task automatic take_result(input string req);
        int n = 0;
        while (!res_valid && n < 2000) begin @(negedge clk); n++; end
        check({req, " result arrives"}, int'(res_valid), 1);
        check({req, " tag"}, int'(res_prev), int'(latch_mode2));
        check({req, " data"}, int'(res_data),
              int'(latch_mode2 ? samp(m_idx - 1) : samp(m_idx)));
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=expired expected=done");
        summary();
    end

    initial begin
        int f0, v0, t_rise, t_err, n, ack_c, val_c;
        logic prev_m2;
        rst_n = 0; run = 0; latch_mode2 = 0; stby_req = 0; nap_req = 0;
        ofs_wr_req = 0; ofs_word = '0; stuck = 0; tie_cs = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 strobes idle", int'({adc_convst_n, adc_cs_n, adc_rd_n}), 7);
        check("R1 drives quiet", int'({adc_wr, bus_oe, res_valid, err_timeout, ofs_ack}), 0);

        // Table walk: R4, R5, R7 across modes and chip-select wiring.
        prev_m2 = 1'b0;
        for (int i = 0; i < 6; i++) begin
            latch_mode2 = VEC[i][7]; tie_cs = VEC[i][6];
            f0 = falls;
            run = 1;
            for (int k = 0; k < int'(VEC[i][5:0]); k++)
                take_result(VEC[i][7] ? "R5" : (VEC[i][6] ? "R7 R4" : "R4"));
            run = 0;
            check("R5 drop count", falls - f0,
                  int'(VEC[i][5:0]) + ((VEC[i][7] && !prev_m2) ? 1 : 0));
            prev_m2 = VEC[i][7];
            repeat (100) @(negedge clk);
        end
        tie_cs = 0;
        check("R2 pulse width", lo_w, CONV_W);
        check("R2 spacing", int'(min_space >= EFF), 1);
        check("R7 read width", rd_w, RD_W);
        check("R6 oe vs read", conflicts, 0);

        // R3 standby holds off starts and clears the deferred history (R5).
        stby_req = 1; run = 1; f0 = falls;
        repeat (400) @(negedge clk);
        check("R3 standby level", int'(adc_stby), 1);
        check("R3 no start in standby", falls - f0, 0);
        stby_req = 0;
        take_result("R5 after standby");
        run = 0;
        check("R5 standby drop", falls - f0, 2);
        repeat (100) @(negedge clk);
        latch_mode2 = 0; nap_req = 1; run = 1; f0 = falls;
        repeat (300) @(negedge clk);
        check("R3 nap level", int'(adc_nap), 1);
        check("R3 no start in nap", falls - f0, 0);
        nap_req = 0; run = 0;
        repeat (100) @(negedge clk);

        // R8 offset write while idle.
        ofs_word = 14'h2A5C; ofs_wr_req = 1;
        @(negedge clk); ofs_wr_req = 0;
        n = 0;
        while (!ofs_ack && n < 100) begin @(negedge clk); n++; end
        check("R8 ack", int'(ofs_ack), 1);
        @(negedge clk);
        check("R8 word latched", int'(m_ofs), 'h2A5C);
        check("R8 write width", wr_w, WR_W);
        check("R8 ack single", int'(ofs_ack), 0);

        // R10 write requested mid-conversion waits for the read.
        run = 1;
        while (adc_convst_n) @(negedge clk);
        run = 0; ofs_word = 14'h1357; ofs_wr_req = 1;
        @(negedge clk); ofs_wr_req = 0;
        ack_c = -1; val_c = -1; n = 0;
        while (ack_c < 0 && n < 1000) begin
            if (res_valid && val_c < 0) val_c = cyc;
            if (ofs_ack) ack_c = cyc;
            @(negedge clk); n++;
        end
        check("R10 read before write", int'(val_c >= 0 && ack_c > val_c), 1);
        check("R10 word latched", int'(m_ofs), 'h1357);
        repeat (100) @(negedge clk);

        // R9 busy never returns.
        stuck = 1; v0 = valids; run = 1;
        while (adc_convst_n) @(negedge clk);
        while (!adc_convst_n) @(negedge clk);
        t_rise = cyc; run = 0; n = 0;
        while (!err_timeout && n < 1000) begin @(negedge clk); n++; end
        t_err = cyc;
        check("R9 timeout reported", int'(err_timeout), 1);
        check("R9 timeout delay", t_err - t_rise, TO);
        @(negedge clk);
        check("R9 single pulse", errs, 1);
        check("R9 no result", valids - v0, 0);
        stuck = 0;
        repeat (20) @(negedge clk);
        run = 1;
        take_result("R9 recovery R4");
        run = 0;
        repeat (50) @(negedge clk);
        summary();
    end
endmodule